// File: doc/BRIEF.md
# Bitstream Field Extractor

This block turns a stream of fixed-size input words into a single continuous bit sequence and hands out fields of any width from 1 to the word width on demand. Words come in through a valid/ready refill port. A word can be byte-reversed on entry when the stream's byte order differs from the host order. The configured bit order then decides whether fields are drawn from the most significant end or the least significant end of each word. A field may start in one word and finish in the next.

A consumer puts a length on `req_len` and raises `req_valid`. The block answers with `fld_valid` and a right-aligned, zero-extended `fld_data` as soon as enough bits are buffered. It holds up to two words of bits. It asks for another word whenever less than one word's worth remains.

Back-pressure works as follows. A refill word transfers on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_data` with `in_valid` low for as long as it likes. A field transfers on a rising edge where `req_valid` and `fld_valid` are both high. While `fld_valid` is low nothing is consumed, so the consumer may hold or change its request. The configuration inputs may only change together with a `flush`.

Top module: `bitfield_unpacker`

## Requirements
- R1: `in_ready` is high exactly when the block is out of reset, `flush` is low and fewer than CW bits are buffered. A word is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R2: When `cfg_big_endian` differs from parameter NATIVE_BIG (default 0, little-endian host), the incoming word's bytes are reversed before it joins the stream. Byte 0 (bits 7:0) becomes bits CW-1:CW-8. When the two match, the word is used unchanged.
- R3: With `cfg_msb_first`=1, each word contributes its bit CW-1 first and its bit 0 last. The first stream bit of a field becomes the field's most significant bit.
- R4: With `cfg_msb_first`=0, each word contributes its bit 0 first and its bit CW-1 last. The first stream bit of a field becomes field bit 0.
- R5: Consecutive words form one gapless bit sequence, so a field may take its leading bits from one word and the rest from the next.
- R6: `fld_valid` is high exactly when `req_valid` is high, `req_len` is within 1..CW, `flush` is low and at least `req_len` bits are buffered. When it is low, no bits are consumed.
- R7: All bits of `fld_data` at positions `req_len` and above are zero.
- R8: If a field transfer and a refill fall in the same cycle, the buffered count becomes old count minus `req_len` plus CW. The new word's bits follow the bits that remain.
- R9: `flush` is synchronous. In its cycle `in_ready` and `fld_valid` are low. In the next cycle zero bits are buffered.
- R10: After reset zero bits are buffered, `in_ready` is high and no field is offered.
- R11: A `req_len` of 0 or greater than CW is never accepted and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous clear of buffered bits |
| cfg_big_endian | input | 1 | Stream byte order: 1 big-endian, 0 little-endian |
| cfg_msb_first | input | 1 | Bit order: 1 most significant first, 0 least significant first |
| in_valid | input | 1 | Refill word present |
| in_ready | output | 1 | Refill word accepted this cycle if valid |
| in_data | input | CW | Refill word |
| req_valid | input | 1 | Field request present |
| req_len | input | $clog2(CW+1) | Requested field width in bits |
| fld_valid | output | 1 | Field delivered this cycle |
| fld_data | output | CW | Field, right-aligned, zero-extended |

## Verification
A refill and an extraction can land on the same clock edge. The bench sets this up by asking for a field while fewer than CW bits are buffered and `in_valid` is high. After such a cycle, every later field must still match a bench-side bit queue. That queue is filled by pushing each word's bits in the configured order and emptied by popping each field. The queue also predicts the exact cycle at which a follow-on request stops being served. A wrong count after the combined cycle therefore shows up either as a wrong field value or as `fld_valid` at the wrong time.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/bfx_byte_order.sv
module bfx_byte_order #(
  parameter int   CW         = 32,
  parameter logic NATIVE_BIG = 1'b0
) (
  input  logic          big_endian,
  input  logic [CW-1:0] raw_word,
  output logic [CW-1:0] ord_word
);
  localparam int NB = CW / 8;

  logic [CW-1:0] rev_word;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev_word[8*b +: 8] = raw_word[8*(NB-1-b) +: 8];
  end

  assign ord_word = (big_endian != NATIVE_BIG) ? rev_word : raw_word;
endmodule

// File: rtl/bfx_bit_store.sv
module bfx_bit_store
  import bfx_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  bit_order_e                  order,
  input  logic                        take,
  input  logic [$clog2(CW+1)-1:0]     take_len,
  input  logic                        load,
  input  logic [CW-1:0]               load_word,
  output logic [2*CW-1:0]             store_q,
  output logic [$clog2(2*CW+1)-1:0]   count_q
);
  localparam int BUF_W = 2 * CW;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [CNT_W-1:0] take_n, rem, cnt_d;
  logic [BUF_W-1:0] shifted, placed, store_d;

  always_comb begin
    take_n = take ? CNT_W'(take_len) : '0;
    rem    = count_q - take_n;
    if (order == ORDER_MSB) begin
      // live bits sit at the top; new word goes right below them
      shifted = store_q << take_n;
      placed  = {load_word, {CW{1'b0}}} >> rem;
    end else begin
      // live bits sit at the bottom; new word goes right above them
      shifted = store_q >> take_n;
      placed  = {{CW{1'b0}}, load_word} << rem;
    end
    store_d = load ? (shifted | placed) : shifted;
    cnt_d   = load ? rem + CNT_W'(CW) : rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      store_q <= '0;
      count_q <= '0;
    end else begin
      store_q <= store_d;
      count_q <= cnt_d;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(BUF_W));

  assert_load_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (count_q < CNT_W'(CW)));

  assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0));
endmodule

// File: rtl/bfx_field_pick.sv
module bfx_field_pick
  import bfx_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  bit_order_e              order,
  input  logic [2*CW-1:0]         store,
  input  logic [$clog2(CW+1)-1:0] len,
  output logic [CW-1:0]           field
);
  localparam int BUF_W = 2 * CW;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [CNT_W-1:0] top_shift;
  logic [CW-1:0]    keep_mask;

  always_comb begin
    top_shift = CNT_W'(BUF_W) - CNT_W'(len);
    keep_mask = ~({CW{1'b1}} << len);
    if (order == ORDER_MSB)
      field = CW'(store >> top_shift);
    else
      field = store[CW-1:0] & keep_mask;
  end

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((field >> len) == '0));
endmodule

// File: rtl/bitfield_unpacker.sv
module bitfield_unpacker
  import bfx_pkg::*;
#(
  parameter int   CW         = 32,
  parameter logic NATIVE_BIG = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    cfg_big_endian,
  input  logic                    cfg_msb_first,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CW-1:0]           in_data,
  input  logic                    req_valid,
  input  logic [$clog2(CW+1)-1:0] req_len,
  output logic                    fld_valid,
  output logic [CW-1:0]           fld_data
);
  localparam int BUF_W = 2 * CW;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int LEN_W = $clog2(CW + 1);

  if (CW != 32 && CW != 64) begin : g_bad_width
    $error("bitfield_unpacker: CW must be 32 or 64");
  end

  bit_order_e       order;
  logic [CW-1:0]    ord_word;
  logic [BUF_W-1:0] store;
  logic [CNT_W-1:0] count;
  logic             len_ok, take, load;

  assign order     = bit_order_e'(cfg_msb_first);
  assign len_ok    = (req_len != '0) && (req_len <= LEN_W'(CW));
  assign in_ready  = rst_n && !flush && (count < CNT_W'(CW));
  assign fld_valid = rst_n && !flush && req_valid && len_ok &&
                     (count >= CNT_W'(req_len));
  assign take      = fld_valid;
  assign load      = in_valid && in_ready;

  bfx_byte_order #(.CW(CW), .NATIVE_BIG(NATIVE_BIG)) u_order (
    .big_endian (cfg_big_endian),
    .raw_word   (in_data),
    .ord_word   (ord_word)
  );

  bfx_bit_store #(.CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .order     (order),
    .take      (take),
    .take_len  (req_len),
    .load      (load),
    .load_word (ord_word),
    .store_q   (store),
    .count_q   (count)
  );

  bfx_field_pick #(.CW(CW)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (fld_valid),
    .order (order),
    .store (store),
    .len   (req_len),
    .field (fld_data)
  );

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fld_valid);

  assert_offer_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fld_valid |-> (req_valid && req_len != '0 && req_len <= LEN_W'(CW)));
endmodule

// File: tb/bitfield_unpacker_test.sv
module bitfield_unpacker_test;
  localparam int CW = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, flush = 1'b0, cfg_be = 1'b0, cfg_msb = 1'b0;
  logic in_valid = 1'b0, in_ready, req_valid = 1'b0, fld_valid;
  logic [CW-1:0] in_data = '0, fld_data;
  logic [LW-1:0] req_len = '0;

  bitfield_unpacker #(.CW(CW), .NATIVE_BIG(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cfg_big_endian(cfg_be), .cfg_msb_first(cfg_msb),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .req_valid(req_valid), .req_len(req_len),
    .fld_valid(fld_valid), .fld_data(fld_data)
  );

  bit q[$];
  int tests = 0, fails = 0, widx = 0;
  logic m_msb = 1'b0, m_be = 1'b0, m_rst = 1'b0;
  logic last_fv;
  logic [CW-1:0] last_data;

  // {msb_first, big_endian, feed, len}
  localparam logic [8:0] VEC [26] = '{
    {1'b1,1'b0,1'b1,6'd5},  {1'b1,1'b0,1'b1,6'd12}, {1'b1,1'b0,1'b1,6'd32},
    {1'b1,1'b0,1'b1,6'd1},  {1'b1,1'b0,1'b0,6'd31}, {1'b1,1'b0,1'b1,6'd20},
    {1'b1,1'b0,1'b1,6'd17}, {1'b1,1'b0,1'b1,6'd32},
    {1'b1,1'b1,1'b1,6'd8},  {1'b1,1'b1,1'b1,6'd3},  {1'b1,1'b1,1'b1,6'd29},
    {1'b1,1'b1,1'b1,6'd32}, {1'b1,1'b1,1'b0,6'd16}, {1'b1,1'b1,1'b1,6'd24},
    {1'b0,1'b0,1'b1,6'd7},  {1'b0,1'b0,1'b1,6'd32}, {1'b0,1'b0,1'b1,6'd9},
    {1'b0,1'b0,1'b1,6'd30}, {1'b0,1'b0,1'b0,6'd6},  {1'b0,1'b0,1'b1,6'd32},
    {1'b0,1'b1,1'b1,6'd16}, {1'b0,1'b1,1'b1,6'd1},  {1'b0,1'b1,1'b1,6'd32},
    {1'b0,1'b1,1'b1,6'd15}, {1'b0,1'b1,1'b1,6'd31}, {1'b0,1'b1,1'b0,6'd2}
  };

  function automatic logic [31:0] gen_word(int k);
    logic [31:0] t;
    t = 32'h9E37_79B9 * 32'(k + 1);
    return t ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] bswap(logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = w[8*(3-b) +: 8];
    return r;
  endfunction

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic [LW-1:0] len, logic feed, logic fl,
                     logic [31:0] w, string tag);
    logic exp_ir, exp_fv;
    logic [CW-1:0] exp_d;
    logic [31:0] ow;
    @(negedge clk);
    rst_n = m_rst; cfg_msb = m_msb; cfg_be = m_be;
    req_valid = v; req_len = len; in_valid = feed; in_data = w; flush = fl;
    #1;
    exp_ir = m_rst && !fl && (q.size() < CW);
    exp_fv = m_rst && !fl && v && len >= 1 && len <= CW && q.size() >= int'(len);
    chk({tag, " in_ready"}, CW'(in_ready), CW'(exp_ir));
    chk({tag, " fld_valid"}, CW'(fld_valid), CW'(exp_fv));
    last_fv = fld_valid;
    last_data = fld_data;
    if (exp_fv && fld_valid) begin
      exp_d = '0;
      for (int i = 0; i < int'(len); i++) begin
        if (m_msb) exp_d = (exp_d << 1) | CW'(q[i]);
        else       exp_d[i] = q[i];
      end
      chk({tag, " field"}, fld_data, exp_d);
    end
    if (!m_rst || fl) q.delete();
    else begin
      if (exp_fv) for (int i = 0; i < int'(len); i++) void'(q.pop_front());
      if (feed && exp_ir) begin
        ow = m_be ? bswap(w) : w;
        if (m_msb) for (int i = CW-1; i >= 0; i--) q.push_back(ow[i]);
        else       for (int i = 0; i < CW; i++) q.push_back(ow[i]);
      end
    end
    @(posedge clk);
  endtask

  task automatic restart(logic msb, logic be);
    m_msb = msb; m_be = be;
    cyc(1'b1, 6'd1, 1'b1, 1'b1, 32'h0, "R9");
  endtask

  task automatic order_case(logic msb, logic be, logic [7:0] exp, string tag);
    restart(msb, be);
    cyc(1'b0, 6'd0, 1'b1, 1'b0, 32'hA1B2_C3D4, tag);
    cyc(1'b1, 6'd8, 1'b0, 1'b0, 32'h0, tag);
    chk({tag, " literal byte"}, last_data, CW'(exp));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic pm, pb;
    string tg;
    // R10: reset state
    m_rst = 1'b0;
    repeat (3) cyc(1'b1, 6'd1, 1'b1, 1'b0, 32'h0, "R10");
    m_rst = 1'b1;
    cyc(1'b1, 6'd1, 1'b0, 1'b0, 32'h0, "R10");
    chk("R10 in_ready after reset", CW'(in_ready), CW'(1));

    // table walk
    pm = 1'b0; pb = 1'b0;
    for (int i = 0; i < 26; i++) begin
      if (i == 0 || VEC[i][8] != pm || VEC[i][7] != pb) begin
        pm = VEC[i][8]; pb = VEC[i][7];
        restart(pm, pb);
      end
      tg = pm ? (pb ? "R2/R3/R5" : "R3/R5") : (pb ? "R2/R4/R5" : "R4/R5");
      cyc(1'b1, VEC[i][5:0], VEC[i][6], 1'b0, gen_word(widx), tg);
      if (VEC[i][6] && last_fv !== 1'bx && q.size() > 0) widx++;
    end

    // R2/R3/R4 literal byte order
    order_case(1'b0, 1'b0, 8'hD4, "R4");
    order_case(1'b1, 1'b0, 8'hA1, "R3");
    order_case(1'b1, 1'b1, 8'hD4, "R2");
    order_case(1'b0, 1'b1, 8'hA1, "R2");

    // R5: field straddling two words, LSB-first
    restart(1'b0, 1'b0);
    cyc(1'b0, 6'd0, 1'b1, 1'b0, 32'h0000_00FF, "R5");
    cyc(1'b1, 6'd4, 1'b1, 1'b0, 32'h0000_0001, "R1");
    cyc(1'b1, 6'd32, 1'b1, 1'b0, 32'h0000_0001, "R8");
    cyc(1'b1, 6'd32, 1'b0, 1'b0, 32'h0, "R5");
    chk("R5 straddle value", last_data, 32'h1000_000F);

    // R11: illegal lengths leave the store untouched
    cyc(1'b1, 6'd0, 1'b0, 1'b0, 32'h0, "R11");
    chk("R11 len0 refused", CW'(last_fv), CW'(0));
    cyc(1'b1, 6'd33, 1'b0, 1'b0, 32'h0, "R11");
    chk("R11 len33 refused", CW'(last_fv), CW'(0));
    cyc(1'b1, 6'd28, 1'b0, 1'b0, 32'h0, "R11");
    chk("R11 remaining bits intact", CW'(last_fv), CW'(1));

    // R8: take and refill in the same cycle, count 28-10+32 = 50
    restart(1'b1, 1'b0);
    cyc(1'b0, 6'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, "R8");
    cyc(1'b1, 6'd4, 1'b0, 1'b0, 32'h0, "R8");
    cyc(1'b1, 6'd10, 1'b1, 1'b0, 32'h1234_5678, "R8");
    chk("R8 combined cycle field", CW'(last_fv), CW'(1));
    cyc(1'b1, 6'd32, 1'b0, 1'b0, 32'h0, "R8");
    cyc(1'b1, 6'd18, 1'b0, 1'b0, 32'h0, "R8");
    chk("R8 last 18 bits served", CW'(last_fv), CW'(1));
    cyc(1'b1, 6'd1, 1'b0, 1'b0, 32'h0, "R6");
    chk("R6 empty store stalls", CW'(last_fv), CW'(0));

    // R9: flush with a full store, then empty
    cyc(1'b0, 6'd0, 1'b1, 1'b0, 32'hCAFE_F00D, "R1");
    cyc(1'b1, 6'd8, 1'b1, 1'b1, 32'h0, "R9");
    chk("R9 no field during flush", CW'(last_fv), CW'(0));
    cyc(1'b1, 6'd1, 1'b0, 1'b0, 32'h0, "R9");
    chk("R9 empty after flush", CW'(last_fv), CW'(0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule